// File: doc/BRIEF.md
# Byte-Serial Command Deserializer

The block turns a stream of bytes on an 8-bit bus into register write commands. A strobe travels with the first byte of each command. The five bytes after it arrive on the next five clock cycles with no strobe. The first two bytes form a 16-bit address, low byte first. The last four bytes form a 32-bit data word, least significant byte first.

The assembled address is masked and compared with a masked base address, which selects a small window of consecutive registers. On a match, the block pulses a write enable for one cycle. During that pulse it presents a short register index (the low address bits) and the data word. A command that does not match still uses up all six byte slots, but it produces no write.

A strobe that arrives in the middle of a command drops the partial command and starts a new one. Reset is active-low and synchronous to the rising clock edge.

Top module: `cmd_deser`

## Requirements
- R1: While rst_ni is low at a rising edge, and after that edge, we_o is 0, idx_o is 0 and data_o is 0.
- R2: A command is six bytes on consecutive cycles. Byte 0 comes with stb_i=1 and is the address low byte. Byte 1 is the address high byte. Bytes 2 to 5 are data bits 7:0, 15:8, 23:16 and 31:24.
- R3: For an accepted command, we_o is 1 for exactly one cycle, which is the cycle right after the edge that captures byte 5. It is 0 in every other cycle.
- R4: A command is accepted when (addr & 0x07fc) == (0x0710 & 0x07fc), so addresses 0x710 to 0x713 are accepted and address bits 15:11 are ignored. During we_o, idx_o equals addr[1:0] and data_o equals the assembled word.
- R5: A command whose address does not match never raises we_o and leaves idx_o and data_o unchanged.
- R6: A non-matching command still takes all six byte cycles. A new command whose strobe comes in the very next cycle is collected and accepted normally.
- R7: A strobe that arrives while a command is being collected, including on the byte 5 cycle, discards the partial command. The strobed byte becomes byte 0 of a new command, and the discarded command never raises we_o.
- R8: Bytes that arrive without stb_i while no command is being collected are ignored: we_o stays 0 and data_o is unchanged.
- R9: idx_o and data_o keep their values from the last accepted command until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| byte_i | input | 8 | Command byte bus |
| stb_i | input | 1 | Marks byte 0 of a command |
| idx_o | output | IDX_W (2) | Local register index of the last accepted command |
| data_o | output | DATA_W (32) | Data word of the last accepted command |
| we_o | output | 1 | One-cycle write enable |

## Verification
A byte position counter that is off by one shows up within the same command. The write pulse then comes a cycle early or late, goes missing, or arrives with its data bytes shifted between lanes, and the bench samples all of this one cycle after byte 5. A busy flag that is cleared or kept wrongly shows up in two ways. Either a command that follows a mismatch or a restart is lost, or stray idle bytes raise a write enable. A capture register enabled at the wrong time corrupts data_o or idx_o, and this is visible on the next pulse or during the hold interval.

// File: rtl/cmd_deser_pkg.sv
package cmd_deser_pkg;
  parameter int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cmd_seq.sv
module cmd_seq #(
  parameter int unsigned NUM_BYTES = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stb_i,
  output logic [NUM_BYTES-1:0] slot_we_o,
  output logic                 last_o
);
  localparam int unsigned POS_W = $clog2(NUM_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_BYTES - 1);

  logic             busy_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos;
  logic             take;

  assign take    = stb_i | busy_q;
  assign cur_pos = stb_i ? '0 : pos_q;
  assign last_o  = busy_q && !stb_i && (pos_q == LAST_POS);

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_slot
    assign slot_we_o[k] = take && (cur_pos == POS_W'(k));
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (stb_i) begin
      // restart on any strobe, partial command dropped
      busy_q <= 1'b1;
      pos_q  <= POS_W'(1);
    end else if (busy_q) begin
      if (pos_q == LAST_POS) begin
        busy_q <= 1'b0;
        pos_q  <= '0;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> (busy_q && pos_q == POS_W'(1)));
  // R8
  idle_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (pos_q == '0));
  // R2
  consec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !stb_i && pos_q != LAST_POS) |=> (busy_q && pos_q == $past(pos_q) + 1'b1));
endmodule

// File: rtl/cmd_asm.sv
module cmd_asm
  import cmd_deser_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 6
) (
  input  logic                        clk_i,
  input  byte_t                       byte_i,
  input  logic [NUM_BYTES-1:0]        slot_we_i,
  output logic [NUM_BYTES*BYTE_W-1:0] frame_o
);
  byte_t slot_q [NUM_BYTES];

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (slot_we_i[k]) slot_q[k] <= byte_i;
    end
    // current byte bypasses its slot so the frame is whole on the last cycle
    assign frame_o[k*BYTE_W +: BYTE_W] = slot_we_i[k] ? byte_i : slot_q[k];
  end
endmodule

// File: rtl/cmd_match.sv
module cmd_match #(
  parameter int unsigned    ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0710,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 16'h07fc
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] BASE_M = BASE_ADDR & ADDR_MASK;
  assign hit_o = ((addr_i & ADDR_MASK) == BASE_M);
endmodule

// File: rtl/cmd_deser.sv
module cmd_deser
  import cmd_deser_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       IDX_W     = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0710,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 16'h07fc
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              stb_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o,
  output logic              we_o
);
  localparam int unsigned NUM_BYTES = (ADDR_W + DATA_W) / BYTE_W;
  localparam int unsigned FRAME_W   = NUM_BYTES * BYTE_W;

  logic [NUM_BYTES-1:0] slot_we;
  logic                 last;
  logic [FRAME_W-1:0]   frame;
  logic [ADDR_W-1:0]    addr;
  logic                 hit;
  logic                 accept;

  logic              we_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  cmd_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (stb_i),
    .slot_we_o (slot_we),
    .last_o    (last)
  );

  cmd_asm #(.NUM_BYTES(NUM_BYTES)) u_asm (
    .clk_i     (clk_i),
    .byte_i    (byte_i),
    .slot_we_i (slot_we),
    .frame_o   (frame)
  );

  assign addr = frame[ADDR_W-1:0];

  cmd_match #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .ADDR_MASK (ADDR_MASK)
  ) u_match (
    .addr_i (addr),
    .hit_o  (hit)
  );

  assign accept = last && hit;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      we_q <= accept;
      if (accept) begin
        idx_q  <= addr[IDX_W-1:0];
        data_q <= frame[ADDR_W +: DATA_W];
      end
    end
  end

  assign we_o   = we_q;
  assign idx_o  = idx_q;
  assign data_o = data_q;

  // R3
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  // R3
  we_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $past(last));
  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_o |-> ($stable(data_o) && $stable(idx_o)));
endmodule

// File: tb/cmd_deser_bench.sv
module cmd_deser_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  din = 8'h00;
  logic        stb = 1'b0;
  logic [1:0]  idx;
  logic [31:0] data;
  logic        we;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0]  m_idx  = 2'd0;
  logic [31:0] m_data = 32'd0;

  always #4 clk = ~clk;

  cmd_deser u_cmd_deser (
    .clk_i (clk), .rst_ni (rst_ni), .byte_i (din), .stb_i (stb),
    .idx_o (idx), .data_o (data), .we_o (we)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input logic [15:0] a, input logic [31:0] d, input int i);
    logic [47:0] f;
    f = {d, a};
    return f[i*8 +: 8];
  endfunction

  task automatic drive_byte(input logic s, input logic [7:0] b);
    @(negedge clk);
    stb = s;
    din = b;
  endtask

  task automatic drive_cmd(input logic [15:0] a, input logic [31:0] d, input int first, input int upto);
    for (int i = first; i < upto; i++) drive_byte(i == 0, frame_byte(a, d, i));
  endtask

  // called right after byte 5 was driven; idle filler byte also exercises R8
  task automatic check_wr(input logic hit, input logic [15:0] a, input logic [31:0] d, input string req);
    check(we == 1'b0, "R3", "we early", 32'(we), 32'd0);
    drive_byte(1'b0, 8'ha5);
    if (hit) begin
      m_idx = a[1:0];
      m_data = d;
    end
    check(we == hit, req, "we", 32'(we), 32'(hit));
    check(idx == m_idx, req, "idx", 32'(idx), 32'(m_idx));
    check(data == m_data, req, "data", data, m_data);
    drive_byte(1'b0, 8'h00);
    check(we == 1'b0, "R3", "we second cycle", 32'(we), 32'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(we == 1'b0, "R1", "we", 32'(we), 32'd0);
    check(idx == 2'd0, "R1", "idx", 32'(idx), 32'd0);
    check(data == 32'd0, "R1", "data", data, 32'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_accept_window;
    // R2 R4: four window addresses plus ignored high bits
    drive_cmd(16'h0710, 32'h11223344, 0, 6); check_wr(1'b1, 16'h0710, 32'h11223344, "R2");
    drive_cmd(16'h0711, 32'hdeadbeef, 0, 6); check_wr(1'b1, 16'h0711, 32'hdeadbeef, "R4");
    drive_cmd(16'h0712, 32'h0000ff01, 0, 6); check_wr(1'b1, 16'h0712, 32'h0000ff01, "R4");
    drive_cmd(16'h0713, 32'hcafe0102, 0, 6); check_wr(1'b1, 16'h0713, 32'hcafe0102, "R4");
    drive_cmd(16'hf712, 32'h89abcdef, 0, 6); check_wr(1'b1, 16'hf712, 32'h89abcdef, "R4");
  endtask

  task automatic t_miss;
    // R5 R9: outside window, outputs keep last accepted values
    drive_cmd(16'h0714, 32'h55555555, 0, 6); check_wr(1'b0, 16'h0714, 32'h55555555, "R5");
    drive_cmd(16'h070f, 32'h66666666, 0, 6); check_wr(1'b0, 16'h070f, 32'h66666666, "R5");
    drive_cmd(16'h0610, 32'h77777777, 0, 6); check_wr(1'b0, 16'h0610, 32'h77777777, "R9");
  endtask

  task automatic t_back_to_back;
    // R6: miss immediately followed by a hit
    drive_cmd(16'h0720, 32'h12121212, 0, 6);
    drive_byte(1'b1, frame_byte(16'h0711, 32'h0badf00d, 0));
    check(we == 1'b0, "R6", "we after miss", 32'(we), 32'd0);
    drive_cmd(16'h0711, 32'h0badf00d, 1, 6);
    check_wr(1'b1, 16'h0711, 32'h0badf00d, "R6");
  endtask

  task automatic t_restart;
    // R7: strobe after 3 bytes, then strobe on the byte-5 cycle
    drive_cmd(16'h0712, 32'haaaaaaaa, 0, 3);
    drive_cmd(16'h0713, 32'h31415926, 0, 6);
    check_wr(1'b1, 16'h0713, 32'h31415926, "R7");
    drive_cmd(16'h0710, 32'hbbbbbbbb, 0, 5);
    drive_cmd(16'h0712, 32'h27182818, 0, 6);
    check_wr(1'b1, 16'h0712, 32'h27182818, "R7");
  endtask

  task automatic t_idle_bytes;
    // R8: a well-formed looking frame without strobe
    drive_cmd(16'h0710, 32'h99999999, 1, 6);
    for (int i = 0; i < 6; i++) begin
      drive_byte(1'b0, frame_byte(16'h0711, 32'h44444444, i));
      check(we == 1'b0, "R8", "we on idle byte", 32'(we), 32'd0);
    end
    repeat (2) drive_byte(1'b0, 8'h00);
    check(we == 1'b0, "R8", "we after idle bytes", 32'(we), 32'd0);
    check(data == m_data, "R8", "data after idle bytes", data, m_data);
  endtask

  task automatic t_hold;
    // R9
    repeat (20) drive_byte(1'b0, 8'h00);
    check(data == m_data, "R9", "data hold", data, m_data);
    check(idx == m_idx, "R9", "idx hold", 32'(idx), 32'(m_idx));
  endtask

  initial begin
    t_reset();
    t_accept_window();
    t_miss();
    t_back_to_back();
    t_restart();
    t_idle_bytes();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule